// File: doc/BRIEF.md
# Multi-Error Correction Apply Sequencer

This block drives the correction phase of an external four-error-capable ECC engine for one 512-byte sector. A start pulse captures eight 10-bit check values. The sequencer writes them into the engine's load register and then reads the four syndrome words. If every syndrome is zero, the sector is clean and the sequencer stops there. Otherwise it clears any stale location result and pulses a location start. It then waits out the engine's status and walks the reported error locations. Each location that falls inside the sector becomes a byte-XOR request to the sector buffer.

The engine is reached through a single-request register port with a valid/ready handshake. The sequencer holds the request until ready. Read data is taken in the same cycle as the handshake. The byte fix port is valid/ready as well: index and mask stay unchanged until the buffer accepts them, and the sequencer issues nothing else in the meantime. Right after the location start, the status field can still show a stale "addresses ready" code. For that reason the sequencer first waits for a working code (4 or more), or for a bounded number of cycles, and only then decodes a final code. The result is a corrected-byte count and a fail flag, both valid while `done` pulses for one cycle.

Top module: `ecc_fix_sequencer`

## Requirements
- R1: During and after reset, `req_valid`, `fix_valid`, `loc_go` and `done` are low until `start` is seen.
- R2: After `start`, the eight captured check values are written to register address 0. The value with index 7 goes first and index 0 goes last. Value i is `exp_codes[10*i+9:10*i]`, and it sits in write-data bits 9:0.
- R3: All four syndrome words are then read, at addresses 1 to 4 in that order. If all four read zero, `done` follows with count 0 and fail 0, and there is no location start and no further access.
- R4: With a nonzero syndrome, one read of address 6 clears the old result. After that read, `loc_go` pulses for exactly one cycle.
- R5: After `loc_go`, the status register (address 5, state in bits 11:8) is polled. A state below 4 is not decoded until a state of 4 or more has been read, or until `WAIT_LIMIT` cycles have passed since the start.
- R6: In the decode phase, states of 4 or more keep the sequencer polling. State 0 leads to one read of address 8 and then done with count 0 and fail 0. State 1 leads to one read of address 8 and then done with fail 1.
- R7: State 2 or 3 gives an error count of 1 plus status bits 17:16. For each error k, the sequencer reads the address word and then the value word. For k of 0 or 1 these are at addresses 6 and 8; for k of 2 or 3 they are at 7 and 9. Odd k uses bits 31:16 and even k uses bits 15:0. The location is the low 10 bits of the chosen half, and the XOR mask is the low 8 bits of the chosen value half.
- R8: The byte index is 519 minus the location. A fix request is issued, and the count goes up, only when that index lies between 0 and 511.
- R9: `fix_index` and `fix_mask` stay stable while `fix_valid` is high and `fix_ready` is low.
- R10: `req_addr`, `req_we` and `req_wdata` stay stable while `req_valid` is high and `req_ready` is low.
- R11: `done` is high for exactly one cycle, with `fix_count` no greater than 4. A `start` that arrives while a sequence is running is ignored, and so is any change to `exp_codes` after capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one sector correction; check values are captured here |
| exp_codes | input | 80 | Eight 10-bit expected check values, value i at bits 10i+9:10i |
| req_valid | output | 1 | Register request pending |
| req_ready | input | 1 | Engine accepts the request this cycle |
| req_we | output | 1 | 1 = write, 0 = read |
| req_addr | output | 4 | Engine register address |
| req_wdata | output | 32 | Write data |
| req_rdata | input | 32 | Read data, valid in the handshake cycle |
| loc_go | output | 1 | One-cycle location-search start |
| fix_valid | output | 1 | Byte fix request pending |
| fix_ready | input | 1 | Buffer accepts the fix this cycle |
| fix_index | output | 9 | Byte index within the sector |
| fix_mask | output | 8 | Bits to invert at that byte |
| done | output | 1 | One-cycle completion strobe |
| fix_count | output | 3 | Bytes corrected, valid with done |
| fail | output | 1 | Uncorrectable sector, valid with done |

## Verification
The bench runs seven sectors:
- All-zero syndromes show that the clean path stops after four reads.
- A syndrome set only in the last word shows that all four words are examined.
- A four-error case carries junk above bit 9 of the address halves. One of its locations maps past the sector. Together these separate masking, half selection, pair selection and range filtering.
- A status sequence of 3, 3, 6, 2 checks the exact number of status reads, which shows that the stale "ready" code is not decoded early.
- A status stuck at 3 shows that the wait bound lets the sequence finish.
- The fail and no-error outcomes check the single terminating read.
- Locations 0 and 520 show that both ends of the range filter reject.
- Slow ready responses on both ports, together with a second start pulse and a change to the check values mid-run, cover the stability and ignore rules.

// File: rtl/efs_pkg.sv
package efs_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_LOAD, S_SYN, S_CLR, S_GO, S_WAIT,
    S_POLL, S_TERM, S_RADDR, S_RVAL, S_FIX, S_DONE
  } seq_state_t;

  // engine register map (addresses decoded by the engine)
  localparam logic [3:0] RA_LOAD   = 4'd0;
  localparam logic [3:0] RA_SYN0   = 4'd1;
  localparam logic [3:0] RA_STAT   = 4'd5;
  localparam logic [3:0] RA_EADDR0 = 4'd6;
  localparam logic [3:0] RA_EADDR1 = 4'd7;
  localparam logic [3:0] RA_EVAL0  = 4'd8;
  localparam logic [3:0] RA_EVAL1  = 4'd9;

  // status word fields
  localparam int ST_LSB  = 8;
  localparam int CNT_LSB = 16;

endpackage

// File: rtl/efs_wait_timer.sv
module efs_wait_timer #(
  parameter int LIMIT = 12500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                               cnt <= '0;
    else if (clear)                           cnt <= '0;
    else if (run && cnt != CW'(LIMIT))        cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == CW'(LIMIT));

endmodule

// File: rtl/efs_err_decode.sv
module efs_err_decode #(
  parameter int CODE_W       = 10,
  parameter int SECTOR_BYTES = 512,
  parameter int IDX_W        = 9
) (
  input  logic [31:0]      addr_word,
  input  logic [31:0]      val_word,
  input  logic             odd,
  output logic [IDX_W-1:0] byte_idx,
  output logic [7:0]       xor_mask,
  output logic             in_range
);
  localparam int MIRROR = SECTOR_BYTES + 7;
  localparam int MW     = $clog2(MIRROR + 1);
  localparam int AW     = ((CODE_W > MW) ? CODE_W : MW) + 1;

  logic [CODE_W-1:0] loc_raw;
  logic [AW-1:0]     loc;
  logic [AW-1:0]     diff;

  assign loc_raw  = odd ? addr_word[16 +: CODE_W] : addr_word[0 +: CODE_W];
  assign xor_mask = odd ? val_word[23:16] : val_word[7:0];
  assign loc      = AW'(loc_raw);
  assign diff     = AW'(MIRROR) - loc;
  assign in_range = (loc <= AW'(MIRROR)) && (loc > AW'(MIRROR - SECTOR_BYTES));
  assign byte_idx = diff[IDX_W-1:0];

  logic unused_bits;
  assign unused_bits = ^{addr_word, val_word[31:24], val_word[15:8], diff};

endmodule

// File: rtl/ecc_fix_sequencer.sv
module ecc_fix_sequencer
  import efs_pkg::*;
#(
  parameter int CODE_W       = 10,
  parameter int NCODE        = 8,
  parameter int SECTOR_BYTES = 512,
  parameter int WAIT_LIMIT   = 12500,
  localparam int IDX_W       = $clog2(SECTOR_BYTES),
  localparam int CIDX_W      = $clog2(NCODE)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [NCODE*CODE_W-1:0] exp_codes,
  output logic                    req_valid,
  input  logic                    req_ready,
  output logic                    req_we,
  output logic [3:0]              req_addr,
  output logic [31:0]             req_wdata,
  input  logic [31:0]             req_rdata,
  output logic                    loc_go,
  output logic                    fix_valid,
  input  logic                    fix_ready,
  output logic [IDX_W-1:0]        fix_index,
  output logic [7:0]              fix_mask,
  output logic                    done,
  output logic [2:0]              fix_count,
  output logic                    fail
);

  seq_state_t        st;
  logic [CODE_W-1:0] code_q [NCODE];
  logic [CIDX_W-1:0] cidx;
  logic [1:0]        sidx;
  logic              syn_any;
  logic [2:0]        num_err;
  logic [1:0]        eidx;
  logic [31:0]       aw_q;
  logic [IDX_W-1:0]  fix_idx_q;
  logic [7:0]        fix_mask_q;
  logic [2:0]        count_q;
  logic              fail_q;

  logic              hs;
  logic [3:0]        rd_state;
  logic [1:0]        rd_cnt;
  logic              t_exp;
  logic              last_err;
  logic [IDX_W-1:0]  dec_idx;
  logic [7:0]        dec_mask;
  logic              dec_ok;

  assign hs       = req_valid && req_ready;
  assign rd_state = req_rdata[ST_LSB +: 4];
  assign rd_cnt   = req_rdata[CNT_LSB +: 2];
  assign last_err = ({1'b0, eidx} == (num_err - 3'd1));

  efs_wait_timer #(.LIMIT(WAIT_LIMIT)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (st == S_GO),
    .run     (st == S_WAIT),
    .expired (t_exp)
  );

  efs_err_decode #(
    .CODE_W(CODE_W), .SECTOR_BYTES(SECTOR_BYTES), .IDX_W(IDX_W)
  ) u_dec (
    .addr_word (aw_q),
    .val_word  (req_rdata),
    .odd       (eidx[0]),
    .byte_idx  (dec_idx),
    .xor_mask  (dec_mask),
    .in_range  (dec_ok)
  );

  // register request generation
  always_comb begin
    req_valid = 1'b1;
    req_we    = 1'b0;
    req_addr  = RA_STAT;
    req_wdata = '0;
    unique case (st)
      S_LOAD: begin
        req_we    = 1'b1;
        req_addr  = RA_LOAD;
        req_wdata = 32'(code_q[cidx]);
      end
      S_SYN:   req_addr = RA_SYN0 + {2'b00, sidx};
      S_CLR:   req_addr = RA_EADDR0;
      S_WAIT,
      S_POLL:  req_addr = RA_STAT;
      S_TERM:  req_addr = RA_EVAL0;
      S_RADDR: req_addr = eidx[1] ? RA_EADDR1 : RA_EADDR0;
      S_RVAL:  req_addr = eidx[1] ? RA_EVAL1 : RA_EVAL0;
      default: req_valid = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cidx       <= '0;
      sidx       <= '0;
      syn_any    <= 1'b0;
      num_err    <= '0;
      eidx       <= '0;
      aw_q       <= '0;
      fix_idx_q  <= '0;
      fix_mask_q <= '0;
      count_q    <= '0;
      fail_q     <= 1'b0;
      for (int i = 0; i < NCODE; i++) code_q[i] <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (start) begin
          for (int i = 0; i < NCODE; i++) code_q[i] <= exp_codes[i*CODE_W +: CODE_W];
          cidx    <= CIDX_W'(NCODE - 1);
          count_q <= '0;
          fail_q  <= 1'b0;
          st      <= S_LOAD;
        end
        S_LOAD: if (hs) begin
          if (cidx == '0) begin
            sidx    <= '0;
            syn_any <= 1'b0;
            st      <= S_SYN;
          end else begin
            cidx <= cidx - 1'b1;
          end
        end
        S_SYN: if (hs) begin
          if (sidx == 2'd3) st <= (syn_any || (|req_rdata)) ? S_CLR : S_DONE;
          else begin
            sidx    <= sidx + 1'b1;
            syn_any <= syn_any || (|req_rdata);
          end
        end
        S_CLR:  if (hs) st <= S_GO;
        S_GO:   st <= S_WAIT;
        S_WAIT: if (hs && (rd_state >= 4'd4 || t_exp)) st <= S_POLL;
        S_POLL: if (hs) begin
          case (rd_state)
            4'd0: st <= S_TERM;
            4'd1: begin fail_q <= 1'b1; st <= S_TERM; end
            4'd2, 4'd3: begin
              num_err <= {1'b0, rd_cnt} + 3'd1;
              eidx    <= '0;
              st      <= S_RADDR;
            end
            default: st <= S_POLL;
          endcase
        end
        S_TERM:  if (hs) st <= S_DONE;
        S_RADDR: if (hs) begin aw_q <= req_rdata; st <= S_RVAL; end
        S_RVAL: if (hs) begin
          if (dec_ok) begin
            fix_idx_q  <= dec_idx;
            fix_mask_q <= dec_mask;
            st         <= S_FIX;
          end else if (last_err) st <= S_DONE;
          else begin eidx <= eidx + 1'b1; st <= S_RADDR; end
        end
        S_FIX: if (fix_ready) begin
          count_q <= count_q + 1'b1;
          if (last_err) st <= S_DONE;
          else begin eidx <= eidx + 1'b1; st <= S_RADDR; end
        end
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign loc_go    = (st == S_GO);
  assign fix_valid = (st == S_FIX);
  assign fix_index = fix_idx_q;
  assign fix_mask  = fix_mask_q;
  assign done      = (st == S_DONE);
  assign fix_count = count_q;
  assign fail      = fail_q;

  // R9
  fix_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fix_valid && !fix_ready |=> fix_valid && $stable(fix_index) && $stable(fix_mask));

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_we) && $stable(req_wdata));

  // R4
  go_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loc_go |=> !loc_go && req_valid && req_addr == RA_STAT);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> fix_count <= 3'd4);

  // R6
  fail_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && fail |-> fix_count == 3'd0);

endmodule

// File: tb/ecc_fix_sequencer_tb.sv
`timescale 1ns/1ps
module ecc_fix_sequencer_tb_top;
  localparam int WL = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [79:0] exp_codes = '0;
  logic        req_valid, req_we, loc_go, fix_valid, done, fail;
  logic        req_ready = 1'b0, fix_ready = 1'b0;
  logic [3:0]  req_addr;
  logic [31:0] req_wdata, req_rdata = '0;
  logic [8:0]  fix_index;
  logic [7:0]  fix_mask;
  logic [2:0]  fix_count;

  always #4 clk = ~clk;

  ecc_fix_sequencer #(.WAIT_LIMIT(WL)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .exp_codes(exp_codes),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_rdata(req_rdata),
    .loc_go(loc_go), .fix_valid(fix_valid), .fix_ready(fix_ready),
    .fix_index(fix_index), .fix_mask(fix_mask), .done(done),
    .fix_count(fix_count), .fail(fail));

  int tests = 0, fails = 0, cyc = 0;
  logic [9:0]  codes [8];
  logic [31:0] syn [4];
  logic [31:0] a1, a2, v1, v2;
  int          stl [$];
  int          stq [$];
  logic [47:0] expq [$];
  int rlat = 0, flat = 0, rwait = 0, fwait = 0;
  int stat_reads = 0, go_cyc = -1, first_after = -1;
  bit done_seen = 0;
  logic [3:0] raddr0;
  logic [8:0] fidx0;

  function automatic logic [47:0] mk(int k, int a, logic [31:0] d);
    return {8'(k), 8'(a), d};
  endfunction

  function automatic int stw(int s, int c);
    return (c << 16) | (s << 8);
  endfunction

  task automatic check(bit ok, string tag, logic [47:0] act, logic [47:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  function automatic string kind_tag(logic [7:0] k);
    case (k)
      8'd1: return "R2 load write";
      8'd2: return "R7 register read order";
      8'd3: return "R8 byte fix";
      8'd4: return "R4 location start";
      default: return "R6 result";
    endcase
  endfunction

  task automatic observe(logic [47:0] it);
    logic [47:0] e;
    if (expq.size() == 0) begin
      check(0, "R11 unexpected transaction", it, 48'h0);
    end else begin
      e = expq.pop_front();
      check(it == e, kind_tag(e[47:40]), it, e);
    end
  endtask

  task automatic serve();
    if (req_addr == 4'd5) begin
      stat_reads++;
      req_rdata = 32'(stq.size() > 1 ? stq.pop_front() : stq[0]);
    end else begin
      if (go_cyc >= 0 && first_after < 0) first_after = cyc;
      case (req_addr)
        4'd1, 4'd2, 4'd3, 4'd4: req_rdata = syn[req_addr - 4'd1];
        4'd6: req_rdata = a1;
        4'd7: req_rdata = a2;
        4'd8: req_rdata = v1;
        4'd9: req_rdata = v2;
        default: req_rdata = 32'h0;
      endcase
      observe(mk(req_we ? 1 : 2, int'(req_addr), req_we ? req_wdata : 32'h0));
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    req_ready = 1'b0;
    fix_ready = 1'b0;
    if (rst_n) begin
      if (req_valid) begin
        if (rwait == 0) raddr0 = req_addr;
        if (rwait >= rlat) begin
          check(req_addr == raddr0, "R10 request held", 48'(req_addr), 48'(raddr0));
          req_ready = 1'b1;
          rwait = 0;
          serve();
        end else rwait++;
      end
      if (fix_valid) begin
        if (fwait == 0) fidx0 = fix_index;
        if (fwait >= flat) begin
          check(fix_index == fidx0, "R9 fix held", 48'(fix_index), 48'(fidx0));
          fix_ready = 1'b1;
          fwait = 0;
          observe(mk(3, 0, 32'({fix_index, fix_mask})));
        end else fwait++;
      end
      if (loc_go) begin
        observe(mk(4, 0, 32'h0));
        go_cyc = cyc;
      end
      if (done) begin
        observe(mk(5, 0, 32'({fail, 1'b0, fix_count})));
        done_seen = 1;
      end
    end
  end

  task automatic build_expected();
    bit any = 0;
    int fin, s, c, cnt;
    for (int i = 7; i >= 0; i--) expq.push_back(mk(1, 0, 32'(codes[i])));
    for (int w = 0; w < 4; w++) begin
      expq.push_back(mk(2, 1 + w, 32'h0));
      if (syn[w] != 0) any = 1;
    end
    if (!any) begin expq.push_back(mk(5, 0, 32'h0)); return; end
    expq.push_back(mk(2, 6, 32'h0));
    expq.push_back(mk(4, 0, 32'h0));
    fin = stl[stl.size() - 1];
    s = (fin >> 8) & 15;
    c = (fin >> 16) & 3;
    if (s <= 1) begin
      expq.push_back(mk(2, 8, 32'h0));
      expq.push_back(mk(5, 0, (s == 1) ? 32'h10 : 32'h0));
      return;
    end
    cnt = 0;
    for (int e = 0; e <= c; e++) begin
      logic [31:0] ar, vr;
      int loc, idx;
      ar = (e > 1) ? a2 : a1;
      vr = (e > 1) ? v2 : v1;
      if (e & 1) begin ar = ar >> 16; vr = vr >> 16; end
      expq.push_back(mk(2, (e > 1) ? 7 : 6, 32'h0));
      expq.push_back(mk(2, (e > 1) ? 9 : 8, 32'h0));
      loc = int'(ar & 32'h3ff);
      idx = 519 - loc;
      if (idx >= 0 && idx < 512) begin
        expq.push_back(mk(3, 0, 32'((idx << 8) | int'(vr & 32'hff))));
        cnt++;
      end
    end
    expq.push_back(mk(5, 0, 32'(cnt)));
  endtask

  task automatic run_case(bit poke);
    for (int i = 0; i < 8; i++) exp_codes[i*10 +: 10] = codes[i];
    stq = stl;
    build_expected();
    stat_reads = 0; go_cyc = -1; first_after = -1; done_seen = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      exp_codes = ~exp_codes;
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    while (!done_seen && cyc < 150000) @(negedge clk);
    repeat (20) @(negedge clk);
    check(expq.size() == 0, "R11 sequence complete, nothing extra", 48'(expq.size()), 48'h0);
    expq.delete();
  endtask

  task automatic set_codes(int base);
    for (int i = 0; i < 8; i++) codes[i] = 10'(base + 37 * i);
  endtask

  initial begin
    wait (cyc > 150000);
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check(!req_valid && !fix_valid, "R1 reset idle ports", 48'({req_valid, fix_valid}), 48'h0);
    check(!done && !loc_go, "R1 reset strobes", 48'({done, loc_go}), 48'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!req_valid && !done, "R1 idle before start", 48'({req_valid, done}), 48'h0);

    // R3 clean sector
    set_codes(1);
    syn = '{32'h0, 32'h0, 32'h0, 32'h0};
    stl = '{stw(2, 0)};
    a1 = 0; a2 = 0; v1 = 0; v2 = 0;
    run_case(0);
    check(go_cyc < 0, "R3 no location start when clean", 48'(go_cyc), 48'hffffffffffff);

    // R7 R8 four errors, junk upper bits, one out of range; R11 busy start ignored
    set_codes(900);
    syn = '{32'h0, 32'h0, 32'h0, 32'h1};
    stl = '{stw(4, 0), stw(2, 3)};
    a1 = 32'h0207_FC0A; v1 = 32'hAA80_5501;
    a2 = 32'h0008_0005; v2 = 32'h003C_00FF;
    rlat = 1; flat = 0;
    run_case(1);

    // R5 stale ready code in wait phase must not be decoded
    set_codes(300);
    syn = '{32'h3, 32'h0, 32'h0, 32'h0};
    stl = '{stw(3, 0), stw(3, 0), stw(6, 0), stw(2, 0)};
    a1 = 32'h0000_0064; v1 = 32'h0000_005A;
    rlat = 2; flat = 3;
    run_case(0);
    check(stat_reads == 4, "R5 status reads before decode", 48'(stat_reads), 48'd4);

    // R6 five or more errors
    set_codes(55);
    syn = '{32'h0, 32'h40, 32'h0, 32'h0};
    stl = '{stw(5, 0), stw(1, 2)};
    rlat = 0; flat = 0;
    run_case(0);

    // R6 engine reports no error
    stl = '{stw(4, 0), stw(0, 0)};
    run_case(0);

    // R5 wait bound expires with stale code held
    set_codes(700);
    stl = '{stw(3, 1)};
    a1 = 32'h0010_0020; v1 = 32'h0011_0022;
    rlat = 1; flat = 1;
    run_case(0);
    check(first_after - go_cyc >= WL, "R5 wait bound honoured",
          48'(first_after - go_cyc), 48'(WL));

    // R8 locations 0 and 520 fall outside the sector
    stl = '{stw(7, 0), stw(7, 0), stw(2, 1)};
    a1 = {16'd520, 16'd0}; v1 = 32'h00FF_00FF;
    rlat = 0; flat = 0;
    run_case(0);
    check(stat_reads == 3, "R6 polling continues on working code", 48'(stat_reads), 48'd3);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule